// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous host and an asynchronous static RAM with a 14-bit word address and a 4-bit shared data bus. The host offers one word at a time through a valid/ready port, marked as a read or a write. The controller holds that address on the memory pins for the whole access. It then plays out the strobe sequence for the access in clock cycles: a setup phase, a strobe phase and a recovery phase. Reads end with a response pulse that carries the sampled word.

Writes are closed by the write-enable strobe, and output enable stays high throughout a write. The controller's data driver, modelled as separate output, enable and input ports for an external pad, switches on only after write enable has been low for one full cycle. After every read the controller adds idle turnaround cycles, so the memory and the controller never drive the bus in the same cycle. Each phase length is a parameter. The bench instantiates a longer setting than the defaults.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after it, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_oe and rsp_valid are 0, and req_ready is 1.
- R2: req_ready is 1 exactly in cycles with no access in progress. A request is taken on a rising edge where req_valid and req_ready are both 1. Its address, data and direction (req_write 1 = write) are held until the access ends.
- R3: A read runs SETUP_CYC cycles with only mem_ce_n low, then PULSE_CYC cycles with mem_ce_n and mem_oe_n low and mem_we_n high, then RECOV_CYC cycles with all strobes high, then TURN_CYC cycles with all strobes high and req_ready 0.
- R4: A read samples mem_dq_in at the edge that ends its last strobe cycle. rsp_valid is 1 for exactly the first recovery cycle, with the sampled word on rsp_rdata. A write never raises rsp_valid.
- R5: A write runs SETUP_CYC cycles with only mem_ce_n low, then PULSE_CYC cycles with mem_ce_n and mem_we_n low, then RECOV_CYC cycles with all strobes high, and then returns to idle with no turnaround.
- R6: mem_oe_n stays 1 in every cycle of a write.
- R7: mem_dq_oe is 1 only in write strobe cycles after the first one, and falls at the same edge where mem_we_n rises. mem_dq_out carries the request's write data.
- R8: mem_addr changes only at an edge where mem_we_n is 1 both before and after. During an access it equals the accepted address.
- R9: mem_dq_oe is never 1 while mem_oe_n is 0, and a read is followed by at least one idle cycle before the next access starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle |
| rsp_rdata | output | DATA_W | Read data |
| mem_addr | output | ADDR_W | Address to the RAM |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Data toward the shared bus pad |
| mem_dq_oe | output | 1 | Pad driver enable |
| mem_dq_in | input | DATA_W | Data from the shared bus pad |

## Verification
The bench targets the first write strobe cycle. A design that turns its driver on there would fight a memory output that is still turning off. It also targets the read sample point: taken one edge late, the word is lost after output enable has risen; taken early, the response pulse lands in the wrong cycle. Read-then-write and write-then-read pairs, issued back to back, expose a missing turnaround cycle as bus contention seen by the memory model. A phase counter that is off by one shows up as a strobe edge one cycle out of place against the per-cycle reference. An address that moves while write enable is low shows up as a word stored at the wrong location and read back later.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
   typedef enum logic [2:0] {
      PH_IDLE,
      PH_SETUP,
      PH_STROBE,
      PH_RECOV,
      PH_TURN
   } phase_e;
endpackage

// File: rtl/sram_phase_timer.sv
// Down counter that measures the length of the current phase.
module sram_phase_timer #(
   parameter int CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_req_hold.sv
// Holds the accepted request for the length of the access.
module sram_req_hold #(
   parameter int ADDR_W = 14,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              wr_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic              wr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         wr_q   <= 1'b0;
      end else if (capture) begin
         addr_q <= addr_in;
         data_q <= data_in;
         wr_q   <= wr_in;
      end
   end
endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
   import sram_ctrl_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int DATA_W    = 4,
   parameter int SETUP_CYC = 1,
   parameter int PULSE_CYC = 2,
   parameter int RECOV_CYC = 1,
   parameter int TURN_CYC  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_we_n,
   output logic              mem_oe_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int MAX_AB  = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
   localparam int MAX_CD  = (RECOV_CYC > TURN_CYC) ? RECOV_CYC : TURN_CYC;
   localparam int MAX_LEN = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int CNT_W   = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

   // Elaboration-time parameter checks
   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("sram_cycle_ctrl: address and data widths must be positive");
      end
      if (SETUP_CYC < 1) begin : g_bad_setup
         $error("sram_cycle_ctrl: SETUP_CYC must be at least 1");
      end
      if (PULSE_CYC < 2) begin : g_bad_pulse
         $error("sram_cycle_ctrl: PULSE_CYC must be at least 2 (driver waits one strobe cycle)");
      end
      if (RECOV_CYC < 1) begin : g_bad_recov
         $error("sram_cycle_ctrl: RECOV_CYC must be at least 1");
      end
      if (TURN_CYC < 1) begin : g_bad_turn
         $error("sram_cycle_ctrl: TURN_CYC must be at least 1");
      end
   endgenerate

   phase_e           phase_q, phase_d;
   logic             accept;
   logic             tmr_done;
   logic             op_wr_q, op_wr_nx;
   logic [CNT_W-1:0] len_m1;

   assign req_ready = (phase_q == PH_IDLE);
   assign accept    = req_valid && req_ready;
   assign op_wr_nx  = accept ? req_write : op_wr_q;

   always_comb begin
      phase_d = phase_q;
      unique case (phase_q)
         PH_IDLE:   if (accept)   phase_d = PH_SETUP;
         PH_SETUP:  if (tmr_done) phase_d = PH_STROBE;
         PH_STROBE: if (tmr_done) phase_d = PH_RECOV;
         PH_RECOV:  if (tmr_done) phase_d = op_wr_q ? PH_IDLE : PH_TURN;
         PH_TURN:   if (tmr_done) phase_d = PH_IDLE;
         default:                 phase_d = PH_IDLE;
      endcase
   end

   always_comb begin
      unique case (phase_d)
         PH_SETUP:  len_m1 = CNT_W'(SETUP_CYC - 1);
         PH_STROBE: len_m1 = CNT_W'(PULSE_CYC - 1);
         PH_RECOV:  len_m1 = CNT_W'(RECOV_CYC - 1);
         PH_TURN:   len_m1 = CNT_W'(TURN_CYC - 1);
         default:   len_m1 = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) phase_q <= PH_IDLE;
      else        phase_q <= phase_d;
   end

   sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (phase_d != phase_q),
      .load_val (len_m1),
      .done     (tmr_done)
   );

   sram_req_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (accept),
      .addr_in (req_addr),
      .data_in (req_wdata),
      .wr_in   (req_write),
      .addr_q  (mem_addr),
      .data_q  (mem_dq_out),
      .wr_q    (op_wr_q)
   );

   // Strobes are registered from the next phase so the pins never glitch.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_ce_n  <= 1'b1;
         mem_we_n  <= 1'b1;
         mem_oe_n  <= 1'b1;
         mem_dq_oe <= 1'b0;
      end else begin
         mem_ce_n  <= !(phase_d == PH_SETUP || phase_d == PH_STROBE);
         mem_we_n  <= !(phase_d == PH_STROBE && op_wr_nx);
         mem_oe_n  <= !(phase_d == PH_STROBE && !op_wr_nx);
         // driver only from the second strobe cycle on
         mem_dq_oe <= (phase_d == PH_STROBE) && (phase_q == PH_STROBE) && op_wr_nx;
      end
   end

   // Read sample at the edge closing the last strobe cycle
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= 1'b0;
         if (phase_q == PH_STROBE && tmr_done && !op_wr_q) begin
            rsp_valid <= 1'b1;
            rsp_rdata <= mem_dq_in;
         end
      end
   end

   assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

   assert_oe_framed_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> !mem_ce_n);

   assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_oe_off_in_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> mem_oe_n);

   assert_drive_after_we_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && !$past(mem_we_n)));

   assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n)));

   assert_no_contention_R9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> mem_oe_n);

   assert_turn_after_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_oe_n) |=> !req_ready);
endmodule

// File: tb/sim_sram_cycle_ctrl.sv
module sim_sram_cycle_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int S_CYC = 2;
   localparam int P_CYC = 3;
   localparam int R_CYC = 1;
   localparam int T_CYC = 2;

   typedef struct {
      logic       rdy, ce_n, we_n, oe_n, dq_oe, rsp, busy, wr;
      logic [3:0] rd, wd;
      logic [13:0] addr;
   } exp_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [13:0] req_addr = '0;
   logic [3:0] req_wdata = '0;
   logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
   logic [3:0] rsp_rdata, mem_dq_out;
   logic [3:0] mem_dq_in = '0;
   logic [13:0] mem_addr;

   int tests = 0, fails = 0;
   bit finished = 1'b0;
   exp_t expq[$];
   logic [3:0] ref_mem[int];
   logic [3:0] sram[int];
   logic last_we_n = 1'b1;
   logic [3:0] last_dq = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sram_cycle_ctrl #(
      .ADDR_W(14), .DATA_W(4), .SETUP_CYC(S_CYC), .PULSE_CYC(P_CYC),
      .RECOV_CYC(R_CYC), .TURN_CYC(T_CYC)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
      .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic exp_t mk(input logic ce_n, we_n, oe_n, dq_oe, rsp, wr,
                               input logic [3:0] rd, wd, input logic [13:0] a);
      exp_t e;
      e.rdy = 1'b0; e.busy = 1'b1; e.ce_n = ce_n; e.we_n = we_n; e.oe_n = oe_n;
      e.dq_oe = dq_oe; e.rsp = rsp; e.wr = wr; e.rd = rd; e.wd = wd; e.addr = a;
      return e;
   endfunction

   // Reference: builds the expected per-cycle picture of one access
   task automatic push_access(input logic w, input logic [13:0] a, input logic [3:0] d);
      logic [3:0] rv;
      if (w) ref_mem[int'(a)] = d;
      rv = ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 4'h0;
      for (int i = 0; i < S_CYC; i++) expq.push_back(mk(0, 1, 1, 0, 0, w, rv, d, a));
      for (int i = 0; i < P_CYC; i++)
         if (w) expq.push_back(mk(0, 0, 1, (i > 0), 0, w, rv, d, a));
         else   expq.push_back(mk(0, 1, 0, 0, 0, w, rv, d, a));
      for (int i = 0; i < R_CYC; i++) expq.push_back(mk(1, 1, 1, 0, (!w && i == 0), w, rv, d, a));
      if (!w) for (int i = 0; i < T_CYC; i++) expq.push_back(mk(1, 1, 1, 0, 0, w, rv, d, a));
   endtask

   // Per-cycle comparison plus the RAM model, all at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         exp_t e;
         string sq;
         if (expq.size() != 0) e = expq.pop_front();
         else begin
            e = mk(1, 1, 1, 0, 0, 0, 4'h0, 4'h0, 14'h0);
            e.rdy = 1'b1; e.busy = 1'b0;
         end
         sq = e.wr ? "R5" : "R3";
         chk("R2", "req_ready", req_ready, e.rdy);
         chk(sq, "mem_ce_n", mem_ce_n, e.ce_n);
         chk(sq, "mem_we_n", mem_we_n, e.we_n);
         if (e.wr) chk("R6", "mem_oe_n in write", mem_oe_n, e.oe_n);
         else      chk("R3", "mem_oe_n", mem_oe_n, e.oe_n);
         chk("R7", "mem_dq_oe", mem_dq_oe, e.dq_oe);
         if (e.dq_oe) chk("R7", "mem_dq_out", mem_dq_out, e.wd);
         if (e.busy) chk("R8", "mem_addr", mem_addr, e.addr);
         chk("R4", "rsp_valid", rsp_valid, e.rsp);
         if (e.rsp) chk("R4", "rsp_rdata", rsp_rdata, e.rd);
         // R9: memory drives while ce/oe low and we high; controller must not
         if (!mem_ce_n && !mem_oe_n && mem_we_n)
            chk("R9", "bus contention", mem_dq_oe, 1'b0);
         // RAM model: write ends when we_n rises
         if (!last_we_n && mem_we_n) sram[int'(mem_addr)] = last_dq;
         if (!mem_we_n && mem_dq_oe) last_dq = mem_dq_out;
         last_we_n = mem_we_n;
         if (!mem_ce_n && !mem_oe_n && mem_we_n)
            mem_dq_in <= sram.exists(int'(mem_addr)) ? sram[int'(mem_addr)] : 4'h0;
         else
            mem_dq_in <= 4'h0;
         if (req_valid && req_ready) push_access(req_write, req_addr, req_wdata);
      end
   end

   // Called just after a rising edge; returns just after the accepting edge
   task automatic issue(input logic w, input logic [13:0] a, input logic [3:0] d);
      bool_wait: begin
         logic seen;
         req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
         do begin
            @(negedge clk); #1;
            seen = req_ready;
         end while (!seen);
         @(posedge clk); #1;
         req_valid = 1'b0;
      end
   endtask

   task automatic gap(input int n);
      repeat (n) begin @(posedge clk); #1; end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs while reset is held
      chk("R1", "reset ce_n", mem_ce_n, 1'b1);
      chk("R1", "reset we_n", mem_we_n, 1'b1);
      chk("R1", "reset oe_n", mem_oe_n, 1'b1);
      chk("R1", "reset dq_oe", mem_dq_oe, 1'b0);
      chk("R1", "reset rsp_valid", rsp_valid, 1'b0);
      chk("R1", "reset ready", req_ready, 1'b1);
      @(posedge clk); #1; rst_n = 1'b1;
      gap(2);
      issue(1, 14'h0000, 4'h5);       // R5 write at lowest address
      issue(1, 14'h3FFF, 4'hA);       // R5 back-to-back write, top address
      issue(0, 14'h3FFF, 4'hx ^ 4'hx); // R3/R4 read back top address
      issue(0, 14'h0000, 4'h0);       // R4 read lowest address
      issue(0, 14'h1234, 4'h0);       // R4 unwritten location reads 0
      issue(1, 14'h2AAA, 4'hC);       // R9 read followed at once by a write
      issue(0, 14'h2AAA, 4'h0);       // write then read same address
      issue(1, 14'h2AAA, 4'h3);       // R7 overwrite
      gap(3);
      issue(0, 14'h2AAA, 4'h0);
      for (int i = 0; i < 24; i++) begin
         issue((i % 3) != 1, 14'((i % 5) * 3001), 4'((i * 7 + 3) & 15));
         if (i % 4 == 0) gap(2);
      end
      // R2: valid held low during idle leaves the bus quiet
      gap(8);
      chk("R2", "queue drained", expq.size(), 0);
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         tests++; fails++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule